// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over 16-bit Management Access

This block lets a 16-bit clause-22 management agent reach a space of 32-bit registers. Transactions arrive already decoded, as a PHY address, a register number, a read/write flag and 16 bits of write data. Read data goes back 16 bits at a time.

The 32-bit word address is built from three parts: a page register, the low three bits of the PHY address and the upper four bits of the register number. A dedicated PHY address holds the page. PHY addresses 0x10 to 0x17 form the data window. Each word is reached as two halves: the even register number carries bits [15:0] and the next odd number carries bits [31:16]. Software always handles the low half first.

Reading the low half takes a snapshot of the upper bits, so that the two halves come from the same moment. Writing the low half only stages the data. The full word is written when the matching high half arrives. A small internal word array stands in for the register space behind the bridge.

Top module: `mdio_paged_bridge`

## Requirements
- R1: After reset the page register is 0, rdata_o is 0, rvalid_o is 0 and every stored word reads as 0.
- R2: A write to PHY address 0x18, register 0, loads the page register from wdata_i[9:0]. A read of that location returns the page, zero-extended to 16 bits. Nothing else changes the page.
- R3: An access at PHY address 0x10..0x17 targets word address {page, phy[2:0], reg[4:1]}. Register bit 0 chooses the half: 0 selects bits [15:0] and 1 selects bits [31:16].
- R4: A low-half read returns the stored bits [15:0] and snapshots bits [31:16] of that word. A later high-half read of the same word returns the snapshot, even if the word was rewritten in between.
- R5: A high-half read of a word other than the last one snapshotted returns the stored bits [31:16].
- R6: A low-half write leaves the stored word unchanged. A high-half write to the same word then stores {high data, staged low data} and clears the staging.
- R7: A high-half write to a word that does not match a pending staged low half is ignored, and the staging stays pending.
- R8: An access at a PHY address outside 0x10..0x18, or at a nonzero register of 0x18, changes nothing, and a read of it returns 0xFFFF.
- R9: A read request produces rvalid_o high with its data on rdata_o one cycle later. After a write or an idle cycle, rvalid_o is low and rdata_o keeps its value.
- R10: Word addresses at or above WORDS read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded management transaction present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 5 | PHY address of the transaction |
| reg_num_i | input | 5 | Register number of the transaction |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| rvalid_o | output | 1 | Pulses one cycle after each read request |

## Verification
The assertions assume that each transaction lasts exactly one cycle with req_valid_i high, and that its address fields are stable in that cycle. They also assume that reset is applied before the first request. The stimulus drives every request on the falling clock edge for a single cycle and leaves the inputs idle between requests. Its random traffic sits mostly inside the populated part of page 0, with occasional page changes, stray PHY addresses and unmatched halves, so the snapshot and staging paths are exercised from both sides.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int unsigned PAGE_W  = 10;
  localparam int unsigned WSEL_W  = 3;
  localparam int unsigned RSEL_W  = 4;
  localparam int unsigned WADDR_W = PAGE_W + WSEL_W + RSEL_W;
  localparam logic [4:0]  PAGE_PHY = 5'h18;
  localparam logic [1:0]  WIN_TOP  = 2'b10;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_WORD = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e            kind;
    logic                 hi;
    logic [WADDR_W-1:0]   waddr;
  } acc_dec_t;
endpackage

// File: rtl/mdio_addr_decode.sv
module mdio_addr_decode
  import mdio_bridge_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic [4:0]        phy_i,
  input  logic [4:0]        reg_i,
  output acc_dec_t          dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.kind = ACC_NONE;
    if (phy_i == PAGE_PHY) begin
      if (reg_i == 5'd0) dec_o.kind = ACC_PAGE;
    end else if (phy_i[4:3] == WIN_TOP) begin
      dec_o.kind  = ACC_WORD;
      dec_o.hi    = reg_i[0];
      dec_o.waddr = {page_i, phy_i[WSEL_W-1:0], reg_i[RSEL_W:1]};
    end
  end
endmodule

// File: rtl/mdio_word_store.sv
module mdio_word_store #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned AW    = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic        w_in_range;
  logic        r_in_range;
  logic [31:0] words [WORDS];

  assign w_in_range = we_i && (waddr_i < AW'(WORDS));
  assign r_in_range = raddr_i < AW'(WORDS);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      word_q <= '0;
      else if (w_in_range && waddr_i[IW-1:0] == IW'(i)) word_q <= wdata_i;
    end
    assign words[i] = word_q;
  end

  assign rdata_o = r_in_range ? words[raddr_i[IW-1:0]] : '0;
endmodule

// File: rtl/mdio_half_stager.sv
module mdio_half_stager
  import mdio_bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_lo_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [15:0]        wdata_i,
  input  logic [31:0]        live_i,
  output logic [15:0]        hi_rdata_o,
  output logic               commit_we_o,
  output logic [31:0]        commit_data_o
);
  logic [15:0]        snap_q;
  logic [WADDR_W-1:0] snap_addr_q;
  logic               snap_vld_q;
  logic [15:0]        stage_q;
  logic [WADDR_W-1:0] stage_addr_q;
  logic               stage_vld_q;
  logic               stage_hit;

  assign stage_hit     = stage_vld_q && (stage_addr_q == waddr_i);
  assign commit_we_o   = wr_hi_i && stage_hit;
  assign commit_data_o = {wdata_i, stage_q};
  assign hi_rdata_o    = (snap_vld_q && snap_addr_q == waddr_i) ? snap_q : live_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q      <= '0;
      snap_addr_q <= '0;
      snap_vld_q  <= 1'b0;
    end else if (rd_lo_i) begin
      snap_q      <= live_i[31:16];
      snap_addr_q <= waddr_i;
      snap_vld_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q      <= '0;
      stage_addr_q <= '0;
      stage_vld_q  <= 1'b0;
    end else if (wr_lo_i) begin
      stage_q      <= wdata_i;
      stage_addr_q <= waddr_i;
      stage_vld_q  <= 1'b1;
    end else if (commit_we_o) begin
      stage_vld_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int unsigned WORDS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_num_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        rvalid_o
);
  logic [PAGE_W-1:0] page_q;
  logic [15:0]       rdata_q;
  logic              rvalid_q;
  acc_dec_t          dec;
  logic              word_acc, rd_req, wr_req;
  logic [31:0]       live_word;
  logic [15:0]       hi_rdata;
  logic              commit_we;
  logic [31:0]       commit_data;
  logic [15:0]       rdata_d;

  assign rd_req   = req_valid_i && !req_write_i;
  assign wr_req   = req_valid_i &&  req_write_i;
  assign word_acc = dec.kind == ACC_WORD;

  mdio_addr_decode u_dec (
    .page_i (page_q),
    .phy_i  (phy_addr_i),
    .reg_i  (reg_num_i),
    .dec_o  (dec)
  );

  mdio_word_store #(.WORDS(WORDS), .AW(WADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit_we),
    .waddr_i (dec.waddr),
    .wdata_i (commit_data),
    .raddr_i (dec.waddr),
    .rdata_o (live_word)
  );

  mdio_half_stager u_stager (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_lo_i       (rd_req && word_acc && !dec.hi),
    .wr_lo_i       (wr_req && word_acc && !dec.hi),
    .wr_hi_i       (wr_req && word_acc &&  dec.hi),
    .waddr_i       (dec.waddr),
    .wdata_i       (wdata_i),
    .live_i        (live_word),
    .hi_rdata_o    (hi_rdata),
    .commit_we_o   (commit_we),
    .commit_data_o (commit_data)
  );

  always_comb begin
    unique case (dec.kind)
      ACC_PAGE: rdata_d = {{(16-PAGE_W){1'b0}}, page_q};
      ACC_WORD: rdata_d = dec.hi ? hi_rdata : live_word[15:0];
      default:  rdata_d = 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
      if (wr_req && dec.kind == ACC_PAGE) page_q <= wdata_i[PAGE_W-1:0];
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/mdio_paged_bridge_chk.sv
module mdio_paged_bridge_chk
  import mdio_bridge_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [4:0]        phy_addr_i,
  input logic [4:0]        reg_num_i,
  input logic [15:0]       rdata_o,
  input logic              rvalid_o,
  input logic [PAGE_W-1:0] page_q
);
  logic rd, page_loc, outside;
  assign rd       = req_valid_i && !req_write_i;
  assign page_loc = (phy_addr_i == PAGE_PHY) && (reg_num_i == 5'd0);
  assign outside  = !page_loc && (phy_addr_i[4:3] != WIN_TOP);

  p_page_only_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(page_q) |-> $past(req_valid_i && req_write_i && page_loc));

  p_page_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && page_loc) |=> rdata_o == {{(16-PAGE_W){1'b0}}, $past(page_q)});

  p_outside_ffff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && outside) |=> rdata_o == 16'hFFFF);

  p_rvalid_after_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);

  p_quiet_no_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (!rvalid_o && $stable(rdata_o)));
endmodule

bind mdio_paged_bridge mdio_paged_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .phy_addr_i  (phy_addr_i),
  .reg_num_i   (reg_num_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .page_q      (page_q)
);

// File: tb/mdio_paged_bridge_test.sv
`timescale 1ns/1ps
module mdio_paged_bridge_test;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_num_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mdio_paged_bridge #(.WORDS(WORDS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .phy_addr_i(phy_addr_i), .reg_num_i(reg_num_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // reference state built from the requirements
  logic [31:0] m_mem [WORDS];
  logic [9:0]  m_page;
  logic [15:0] m_snap;
  logic [16:0] m_snap_a;
  bit          m_snap_v;
  logic [15:0] m_stg;
  logic [16:0] m_stg_a;
  bit          m_stg_v;
  logic [15:0] m_last;

  function automatic void model_reset();
    for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    m_page = '0; m_snap = '0; m_snap_a = '0; m_snap_v = 0;
    m_stg = '0; m_stg_a = '0; m_stg_v = 0; m_last = '0;
  endfunction

  function automatic logic [15:0] model_access(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
    logic [16:0] wa;
    logic [31:0] live;
    if (phy == 5'h18) begin
      if (rg != 0) return 16'hFFFF;
      if (wr) m_page = wd[9:0];
      return {6'b0, m_page};
    end
    if (phy[4:3] != 2'b10) return 16'hFFFF;
    wa   = {m_page, phy[2:0], rg[4:1]};
    live = (wa < WORDS) ? m_mem[wa[5:0]] : 32'h0;
    if (!rg[0]) begin
      if (wr) begin m_stg = wd; m_stg_a = wa; m_stg_v = 1; return 16'h0; end
      m_snap = live[31:16]; m_snap_a = wa; m_snap_v = 1;
      return live[15:0];
    end
    if (wr) begin
      if (m_stg_v && m_stg_a == wa) begin
        if (wa < WORDS) m_mem[wa[5:0]] = {wd, m_stg};
        m_stg_v = 0;
      end
      return 16'h0;
    end
    return (m_snap_v && m_snap_a == wa) ? m_snap : live[31:16];
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; phy_addr_i = phy; reg_num_i = rg; wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic do_read(logic [4:0] phy, logic [4:0] rg, string req);
    logic [15:0] exp;
    exp = model_access(0, phy, rg, 16'h0);
    issue(0, phy, rg, 16'h0);
    check(rvalid_o === 1'b1 && rdata_o === exp, req, rdata_o, exp);
    m_last = exp;
  endtask

  task automatic do_write(logic [4:0] phy, logic [4:0] rg, logic [15:0] wd, bit chk);
    void'(model_access(1, phy, rg, wd));
    issue(1, phy, rg, wd);
    if (chk) check(rvalid_o === 1'b0 && rdata_o === m_last, "R9", rdata_o, m_last);
  endtask

  task automatic write_word(logic [4:0] phy, logic [4:0] rg_even, logic [31:0] v);
    do_write(phy, rg_even, v[15:0], 0);
    do_write(phy, rg_even | 5'd1, v[31:16], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    check(rdata_o === 16'h0 && rvalid_o === 1'b0, "R1", rdata_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(rdata_o === 16'h0 && rvalid_o === 1'b0, "R1", rdata_o, 16'h0);
    do_read(5'h18, 5'd0, "R1");
    do_read(5'h13, 5'd6, "R1");
    do_read(5'h13, 5'd7, "R1");

    // page load and readback
    do_write(5'h18, 5'd0, 16'hFEA5, 1);
    do_read(5'h18, 5'd0, "R2");
    do_write(5'h18, 5'd0, 16'h0000, 1);
    do_read(5'h18, 5'd0, "R2");

    // address composition and halves
    write_word(5'h11, 5'd4, 32'hABCD_1234);
    do_read(5'h11, 5'd4, "R3");
    do_read(5'h11, 5'd5, "R3");
    do_read(5'h10, 5'd4, "R3");
    do_read(5'h11, 5'd6, "R3");

    // staged low not visible until high
    do_write(5'h11, 5'd4, 16'h5555, 1);
    do_read(5'h11, 5'd4, "R6");
    do_write(5'h11, 5'd5, 16'h6666, 1);
    do_read(5'h11, 5'd4, "R6");
    do_read(5'h11, 5'd5, "R6");

    // snapshot consistency across a rewrite
    do_read(5'h11, 5'd4, "R4");
    write_word(5'h11, 5'd4, 32'h0002_0001);
    do_read(5'h11, 5'd5, "R4");
    do_read(5'h11, 5'd4, "R4");
    do_read(5'h11, 5'd5, "R4");

    // high read without a matching snapshot
    write_word(5'h12, 5'd8, 32'hC0DE_BEEF);
    do_read(5'h12, 5'd9, "R5");

    // unmatched high write
    do_write(5'h10, 5'd2, 16'h1111, 1);
    do_write(5'h10, 5'd9, 16'h2222, 1);
    do_read(5'h10, 5'd8, "R7");
    do_read(5'h10, 5'd9, "R7");
    do_write(5'h10, 5'd3, 16'h3333, 1);
    do_read(5'h10, 5'd2, "R7");
    do_read(5'h10, 5'd3, "R7");

    // outside the window
    do_read(5'h05, 5'd0, "R8");
    do_read(5'h19, 5'd2, "R8");
    do_read(5'h18, 5'd3, "R8");
    do_write(5'h18, 5'd1, 16'h0003, 1);
    do_read(5'h18, 5'd0, "R8");
    do_write(5'h0F, 5'd4, 16'h7777, 1);
    do_write(5'h0F, 5'd5, 16'h8888, 1);
    do_read(5'h17, 5'd4, "R8");
    do_read(5'h17, 5'd5, "R8");

    // beyond the populated words
    do_write(5'h18, 5'd0, 16'h0001, 1);
    write_word(5'h10, 5'd0, 32'h1357_9BDF);
    do_read(5'h10, 5'd0, "R10");
    do_read(5'h10, 5'd1, "R10");
    write_word(5'h14, 5'd0, 32'h2468_ACE0);
    do_read(5'h14, 5'd0, "R10");
    do_write(5'h18, 5'd0, 16'h0000, 1);
    do_read(5'h10, 5'd0, "R10");

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      int unsigned sel;
      logic [4:0] phy, rg;
      sel = $urandom % 10;
      phy = 5'h10 | 5'(($urandom % 8 < 6) ? ($urandom % 4) : ($urandom % 8));
      rg  = 5'(($urandom % 16) << 1);
      case (sel)
        0: do_write(5'h18, 5'd0, 16'(($urandom % 5 == 0) ? 1 : 0), 1);
        1, 2, 3: write_word(phy, rg, $urandom);
        4: begin
          logic [4:0] rp;
          rp = 5'(5'h0C + $urandom % 16);
          if ($urandom % 2) do_write(rp, 5'($urandom), 16'($urandom), 1);
          else              do_read(rp, 5'($urandom), "R8");
        end
        5: do_write(phy, rg | 5'(($urandom % 2)), 16'($urandom), 1);
        default: begin
          do_read(phy, rg, "R4");
          do_read(phy, rg | 5'd1, "R4");
        end
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule